// File: doc/BRIEF.md
# DRAM Bank Timing Guard

This block sits beside a DRAM command scheduler and answers one question every cycle: may the command now on offer be sent to the device? The scheduler presents a candidate command (activate, column read, column write, precharge, refresh or no-op) with a bank index and a row address. The guard answers combinationally from its registered per-bank and per-rank history. It keeps, for every bank, whether a row is open and which one. It also keeps the cycles elapsed since the bank's last activate, precharge and write, a rank-wide record of the four most recent activates, and the time since the last refresh. Every timing limit is a parameter counted in memory-clock cycles.

When the scheduler asserts the issue strobe on a legal command, the guard updates its state. For column commands it reports, one cycle later, whether the access was a row hit, a row miss or a row conflict, together with the access latency that class implies. It also raises a marker on the cycle when read data is due back or write data must be driven. An illegal command offered with the strobe is refused: the bank state is left untouched and a sticky violation flag is set.

Top module: `dram_timing_guard`

## Requirements
- R1: Command codes on `cmd_kind` are 0 no-op, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh. A no-op is always legal and codes 6 and 7 are never legal.
- R2: A read or write is legal only when its bank is open on the same row, and at least T_RCD cycles (default 18) have passed since that bank's activate.
- R3: A precharge to an open bank is legal only once T_RAS cycles (default 38) have passed since its activate. A precharge to a closed bank is legal and changes nothing.
- R4: An activate is legal only to a closed bank. At least T_RP cycles (default 18) must have passed since that bank's precharge, and at least T_RC cycles (default 56) since its previous activate.
- R5: An activate is illegal while the oldest of the rank's last four activates is fewer than T_FAW cycles (default 30) old.
- R6: A refresh is legal only when every bank is closed and has been for at least T_RP cycles. After a refresh, every command except no-op is illegal for T_RFC cycles (default 560).
- R7: A read to a bank is illegal until T_WTR cycles (default 10) after the last write to that bank.
- R8: One cycle after a legal read or write is issued, `acc_valid` pulses and `acc_class` gives 0 for a hit (no activate since the bank's previous column access), 1 for a miss (first access after an activate that opened a bank with no earlier row, or the same row it held before), or 2 for a conflict (first access after an activate that replaced a different earlier row). `acc_lat` is CL for a hit, T_RCD+CL for a miss, and T_RP+T_RCD+CL for a conflict.
- R9: `rd_due` is high during the one cycle whose closing edge is CL cycles (default 16) after the edge that accepted a read. `wr_due` does the same CWL cycles (default 14) after a write.
- R10: An illegal command offered with `cmd_issue` sets `violation`, which stays set until reset. Such a command changes no bank state.
- R11: After reset all banks are closed, every timer counts as satisfied, and `violation`, `acc_valid`, `rd_due` and `wr_due` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_kind | input | 3 | Candidate command code |
| cmd_bank | input | $clog2(NUM_BANKS) | Target bank |
| cmd_row | input | ROW_W | Target row |
| cmd_issue | input | 1 | Issue strobe for the candidate |
| cmd_legal | output | 1 | Candidate may be issued this cycle |
| acc_valid | output | 1 | Classification of the last column command is valid |
| acc_class | output | 2 | 0 hit, 1 miss, 2 conflict |
| acc_lat | output | LAT_W | Latency implied by the class |
| rd_due | output | 1 | Read data returns at the next edge |
| wr_due | output | 1 | Write data must be driven at the next edge |
| violation | output | 1 | Sticky illegal-issue flag |

## Verification
A bank counter that is off by one shows at the ports on the very cycle the matching probe is offered. `cmd_legal` flips one cycle early or late at the T_RCD, T_RAS, T_RP, T_WTR, T_FAW or T_RFC boundary, so each limit is probed one cycle before and on its first legal cycle. A wrong open-row record or a missed fresh-activate flag appears one cycle after the next column command, as a wrong `acc_class` or `acc_lat`. A bank that an illegal precharge wrongly closed shows up as a column command being refused a few cycles later. A faulty activate history shows on the fifth activate inside the window.

// File: rtl/dtg_pkg.sv
`timescale 1ns/1ps
package dtg_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5
  } cmd_e;

  typedef enum logic [1:0] {
    ACC_HIT  = 2'd0,
    ACC_MISS = 2'd1,
    ACC_CONF = 2'd2
  } acc_e;
endpackage

// File: rtl/dtg_bank.sv
`timescale 1ns/1ps
// Per-bank row state and elapsed-cycle counters.
module dtg_bank
  import dtg_pkg::*;
#(
  parameter int ROW_W = 8,
  parameter int T_RCD = 18,
  parameter int T_RAS = 38,
  parameter int T_RP  = 18,
  parameter int T_RC  = 56,
  parameter int T_WTR = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  cmd_e             kind,
  input  logic [ROW_W-1:0] row,
  input  logic             commit,
  output logic             is_open,
  output logic             ok,
  output logic             ref_ready,
  output logic             fresh,
  output logic             conflict
);
  localparam int M1   = (T_RCD > T_RAS) ? T_RCD : T_RAS;
  localparam int M2   = (T_RP > T_RC) ? T_RP : T_RC;
  localparam int M3   = (M1 > M2) ? M1 : M2;
  localparam int TMAX = (M3 > T_WTR) ? M3 : T_WTR;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] LIM   = TW'(TMAX);
  localparam logic [TW-1:0] C_RCD = TW'(T_RCD);
  localparam logic [TW-1:0] C_RAS = TW'(T_RAS);
  localparam logic [TW-1:0] C_RP  = TW'(T_RP);
  localparam logic [TW-1:0] C_RC  = TW'(T_RC);
  localparam logic [TW-1:0] C_WTR = TW'(T_WTR);
  localparam logic [TW-1:0] ONE   = TW'(1);

  logic [TW-1:0]    since_act, since_pre, since_wr;
  logic [ROW_W-1:0] open_row;
  logic             had_row;

  function automatic logic [TW-1:0] bump(input logic [TW-1:0] v);
    return (v == LIM) ? LIM : v + ONE;
  endfunction

  wire take = commit & sel;
  wire row_match = is_open && (row == open_row);

  always_comb begin
    case (kind)
      CMD_ACT: ok = !is_open && (since_pre >= C_RP) && (since_act >= C_RC);
      CMD_RD:  ok = row_match && (since_act >= C_RCD) && (since_wr >= C_WTR);
      CMD_WR:  ok = row_match && (since_act >= C_RCD);
      CMD_PRE: ok = !is_open || (since_act >= C_RAS);
      default: ok = 1'b1;
    endcase
  end

  assign ref_ready = !is_open && (since_pre >= C_RP);

  always_ff @(posedge clk) begin
    if (rst) begin
      is_open   <= 1'b0;
      open_row  <= '0;
      had_row   <= 1'b0;
      fresh     <= 1'b0;
      conflict  <= 1'b0;
      since_act <= LIM;
      since_pre <= LIM;
      since_wr  <= LIM;
    end else begin
      since_act <= (take && kind == CMD_ACT) ? ONE : bump(since_act);
      since_pre <= (take && kind == CMD_PRE && is_open) ? ONE : bump(since_pre);
      since_wr  <= (take && kind == CMD_WR) ? ONE : bump(since_wr);
      if (take) begin
        case (kind)
          CMD_ACT: begin
            is_open  <= 1'b1;
            open_row <= row;
            had_row  <= 1'b1;
            fresh    <= 1'b1;
            conflict <= had_row && (open_row != row);
          end
          CMD_RD, CMD_WR: fresh <= 1'b0;
          CMD_PRE: is_open <= 1'b0;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dtg_faw.sv
`timescale 1ns/1ps
// Rolling activate window: timestamps of the last N_ACT activates.
module dtg_faw #(
  parameter int N_ACT = 4,
  parameter int T_FAW = 30,
  parameter int TS_W  = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic act_commit,
  output logic faw_ok
);
  localparam logic [TS_W-1:0] WIN = TS_W'(T_FAW);

  logic [TS_W-1:0] now;
  logic [TS_W-1:0] stamp [N_ACT];
  logic [N_ACT-1:0] vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      now <= '0;
      vld <= '0;
    end else begin
      now <= now + TS_W'(1);
      if (act_commit) vld <= {vld[N_ACT-2:0], 1'b1};
    end
  end

  generate
    for (genvar i = 0; i < N_ACT; i++) begin : g_stamp
      always_ff @(posedge clk) begin
        if (rst) stamp[i] <= '0;
        else if (act_commit) stamp[i] <= (i == 0) ? now : stamp[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign faw_ok = !vld[N_ACT-1] || ((now - stamp[N_ACT-1]) >= WIN);
endmodule

// File: rtl/dram_timing_guard.sv
`timescale 1ns/1ps
module dram_timing_guard
  import dtg_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 8,
  parameter int T_RCD     = 18,
  parameter int T_RAS     = 38,
  parameter int T_RP      = 18,
  parameter int T_RC      = 56,
  parameter int T_FAW     = 30,
  parameter int T_RFC     = 560,
  parameter int T_WTR     = 10,
  parameter int CL        = 16,
  parameter int CWL       = 14,
  parameter int BW        = $clog2(NUM_BANKS),
  parameter int LAT_W     = $clog2(T_RP + T_RCD + CL + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       cmd_kind,
  input  logic [BW-1:0]    cmd_bank,
  input  logic [ROW_W-1:0] cmd_row,
  input  logic             cmd_issue,
  output logic             cmd_legal,
  output logic             acc_valid,
  output logic [1:0]       acc_class,
  output logic [LAT_W-1:0] acc_lat,
  output logic             rd_due,
  output logic             wr_due,
  output logic             violation
);
  localparam int RFW = $clog2(T_RFC + 1);
  localparam logic [RFW-1:0]   RFC_C    = RFW'(T_RFC);
  localparam logic [LAT_W-1:0] LAT_HIT  = LAT_W'(CL);
  localparam logic [LAT_W-1:0] LAT_MISS = LAT_W'(T_RCD + CL);
  localparam logic [LAT_W-1:0] LAT_CONF = LAT_W'(T_RP + T_RCD + CL);

  cmd_e kind;
  assign kind = cmd_e'(cmd_kind);

  logic [NUM_BANKS-1:0] bank_open, bank_ok, bank_ref_rdy, bank_fresh, bank_conf;
  logic [RFW-1:0]       since_ref;
  logic                 faw_ok, commit, busy;
  logic [CL-1:0]        rd_pipe;
  logic [CWL-1:0]       wr_pipe;

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      dtg_bank #(
        .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RAS(T_RAS),
        .T_RP(T_RP), .T_RC(T_RC), .T_WTR(T_WTR)
      ) u_bank (
        .clk(clk), .rst(rst),
        .sel(cmd_bank == BW'(b)), .kind(kind), .row(cmd_row), .commit(commit),
        .is_open(bank_open[b]), .ok(bank_ok[b]), .ref_ready(bank_ref_rdy[b]),
        .fresh(bank_fresh[b]), .conflict(bank_conf[b])
      );
    end
  endgenerate

  dtg_faw #(.N_ACT(4), .T_FAW(T_FAW), .TS_W(32)) u_faw (
    .clk(clk), .rst(rst),
    .act_commit(commit && kind == CMD_ACT),
    .faw_ok(faw_ok)
  );

  assign busy = since_ref < RFC_C;

  always_comb begin
    case (kind)
      CMD_NOP:                 cmd_legal = 1'b1;
      CMD_ACT:                 cmd_legal = !busy && bank_ok[cmd_bank] && faw_ok;
      CMD_RD, CMD_WR, CMD_PRE: cmd_legal = !busy && bank_ok[cmd_bank];
      CMD_REF:                 cmd_legal = !busy && (&bank_ref_rdy);
      default:                 cmd_legal = 1'b0;
    endcase
  end

  assign commit = cmd_issue && cmd_legal && (kind != CMD_NOP);
  wire col_go = commit && (kind == CMD_RD || kind == CMD_WR);

  always_ff @(posedge clk) begin
    if (rst) begin
      since_ref <= RFC_C;
      violation <= 1'b0;
      acc_valid <= 1'b0;
      acc_class <= ACC_HIT;
      acc_lat   <= '0;
      rd_pipe   <= '0;
      wr_pipe   <= '0;
    end else begin
      if (commit && kind == CMD_REF) since_ref <= RFW'(1);
      else if (busy)                 since_ref <= since_ref + RFW'(1);
      if (cmd_issue && !cmd_legal) violation <= 1'b1;
      acc_valid <= col_go;
      if (col_go) begin
        if (!bank_fresh[cmd_bank]) begin
          acc_class <= ACC_HIT;  acc_lat <= LAT_HIT;
        end else if (bank_conf[cmd_bank]) begin
          acc_class <= ACC_CONF; acc_lat <= LAT_CONF;
        end else begin
          acc_class <= ACC_MISS; acc_lat <= LAT_MISS;
        end
      end
      rd_pipe <= (rd_pipe << 1) | CL'(commit && kind == CMD_RD);
      wr_pipe <= (wr_pipe << 1) | CWL'(commit && kind == CMD_WR);
    end
  end

  assign rd_due = rd_pipe[CL-1];
  assign wr_due = wr_pipe[CWL-1];
endmodule

// File: rtl/dtg_checker.sv
`timescale 1ns/1ps
module dtg_checker #(
  parameter int NUM_BANKS = 8,
  parameter int CL        = 16,
  parameter int LAT_W     = 6
) (
  input logic                 clk,
  input logic                 rst,
  input logic [2:0]           cmd_kind,
  input logic                 cmd_issue,
  input logic                 cmd_legal,
  input logic                 acc_valid,
  input logic [1:0]           acc_class,
  input logic [LAT_W-1:0]     acc_lat,
  input logic                 violation,
  input logic [NUM_BANKS-1:0] bank_open
);
  p_nop_legal_r1: assert property (@(posedge clk) disable iff (rst)
    (cmd_kind == 3'd0) |-> cmd_legal);

  p_viol_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    violation |=> violation);

  p_viol_set_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd_issue && !cmd_legal) |=> violation);

  p_class_source_r8: assert property (@(posedge clk) disable iff (rst)
    acc_valid |-> $past(cmd_issue && cmd_legal && (cmd_kind == 3'd2 || cmd_kind == 3'd3)));

  p_hit_latency_r8: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_class == 2'd0) |-> (acc_lat == LAT_W'(CL)));

  p_class_range_r8: assert property (@(posedge clk) disable iff (rst)
    acc_valid |-> (acc_class != 2'd3));

  p_ref_all_closed_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_issue && cmd_legal && cmd_kind == 3'd5) |-> (bank_open == '0));

  p_ref_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_issue && cmd_legal && cmd_kind == 3'd5) |=> !(cmd_legal && cmd_kind != 3'd0));
endmodule

bind dram_timing_guard dtg_checker #(
  .NUM_BANKS(NUM_BANKS), .CL(CL), .LAT_W(LAT_W)
) u_chk (
  .clk(clk), .rst(rst), .cmd_kind(cmd_kind), .cmd_issue(cmd_issue),
  .cmd_legal(cmd_legal), .acc_valid(acc_valid), .acc_class(acc_class),
  .acc_lat(acc_lat), .violation(violation), .bank_open(bank_open)
);

// File: tb/sim_dram_timing_guard.sv
`timescale 1ns/1ps
module sim_dram_timing_guard;
  localparam int NB = 8, RW = 8;
  localparam int T_RCD = 18, T_RAS = 38, T_RP = 18, T_RC = 56;
  localparam int T_FAW = 30, T_RFC = 560, T_WTR = 10, CL = 16, CWL = 14;
  localparam int BW = 3, LW = 6;
  localparam logic [2:0] NOP = 0, ACT = 1, RD = 2, WR = 3, PRE = 4, REF = 5;

  logic clk = 1'b0, rst = 1'b1;
  logic [2:0] cmd_kind = NOP;
  logic [BW-1:0] cmd_bank = '0;
  logic [RW-1:0] cmd_row = '0;
  logic cmd_issue = 1'b0;
  logic cmd_legal, acc_valid, rd_due, wr_due, violation;
  logic [1:0] acc_class;
  logic [LW-1:0] acc_lat;
  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dram_timing_guard #(
    .NUM_BANKS(NB), .ROW_W(RW), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP),
    .T_RC(T_RC), .T_FAW(T_FAW), .T_RFC(T_RFC), .T_WTR(T_WTR), .CL(CL), .CWL(CWL)
  ) u0 (
    .clk(clk), .rst(rst), .cmd_kind(cmd_kind), .cmd_bank(cmd_bank),
    .cmd_row(cmd_row), .cmd_issue(cmd_issue), .cmd_legal(cmd_legal),
    .acc_valid(acc_valid), .acc_class(acc_class), .acc_lat(acc_lat),
    .rd_due(rd_due), .wr_due(wr_due), .violation(violation)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic probe(input logic [2:0] k, input int b, input int r,
                       input logic exp, input string req, input string what);
    cmd_kind = k; cmd_bank = BW'(b); cmd_row = RW'(r); cmd_issue = 1'b0;
    #1;
    check(req, what, 32'(cmd_legal), 32'(exp));
  endtask

  task automatic issue(input logic [2:0] k, input int b, input int r,
                       input logic exp, input string req);
    cmd_kind = k; cmd_bank = BW'(b); cmd_row = RW'(r); cmd_issue = 1'b1;
    #1;
    check(req, "legal at issue", 32'(cmd_legal), 32'(exp));
    @(posedge clk);
    @(negedge clk);
    cmd_issue = 1'b0; cmd_kind = NOP;
  endtask

  task automatic t_reset;
    check("R11", "violation", 32'(violation), 0);
    check("R11", "acc_valid", 32'(acc_valid), 0);
    check("R11", "rd_due", 32'(rd_due), 0);
    check("R11", "wr_due", 32'(wr_due), 0);
    probe(ACT, 0, 5, 1'b1, "R11", "act after reset");
    probe(RD, 0, 5, 1'b0, "R11", "rd to closed bank");
    probe(REF, 0, 0, 1'b1, "R11", "ref after reset");
    probe(3'd7, 0, 0, 1'b0, "R1", "code 7");
    probe(3'd6, 0, 0, 1'b0, "R1", "code 6");
    probe(NOP, 0, 0, 1'b1, "R1", "nop");
  endtask

  task automatic t_rcd_miss_hit;
    issue(ACT, 0, 5, 1'b1, "R2");
    idle(T_RCD - 2);
    probe(RD, 0, 5, 1'b0, "R2", "rd one cycle early");
    probe(WR, 0, 5, 1'b0, "R2", "wr one cycle early");
    idle(1);
    probe(RD, 0, 5, 1'b1, "R2", "rd at trcd");
    probe(RD, 0, 6, 1'b0, "R2", "rd to other row");
    issue(RD, 0, 5, 1'b1, "R2");
    check("R8", "miss valid", 32'(acc_valid), 1);
    check("R8", "miss class", 32'(acc_class), 1);
    check("R8", "miss latency", 32'(acc_lat), T_RCD + CL);
    idle(CL - 2);
    check("R9", "rd_due early", 32'(rd_due), 0);
    idle(1);
    check("R9", "rd_due on time", 32'(rd_due), 1);
    issue(RD, 0, 5, 1'b1, "R8");
    check("R8", "hit class", 32'(acc_class), 0);
    check("R8", "hit latency", 32'(acc_lat), CL);
  endtask

  task automatic t_ras_rp_conflict;
    issue(ACT, 1, 3, 1'b1, "R4");
    probe(ACT, 0, 7, 1'b0, "R4", "act to open bank");
    idle(T_RAS - 2);
    probe(PRE, 1, 0, 1'b0, "R3", "pre before tras");
    idle(1);
    probe(PRE, 1, 0, 1'b1, "R3", "pre at tras");
    issue(PRE, 1, 0, 1'b1, "R3");
    idle(T_RP - 2);
    probe(ACT, 1, 9, 1'b0, "R4", "act before trp/trc");
    idle(1);
    probe(ACT, 1, 9, 1'b1, "R4", "act at trp/trc");
    issue(ACT, 1, 9, 1'b1, "R4");
    idle(T_RCD - 1);
    issue(RD, 1, 9, 1'b1, "R8");
    check("R8", "conflict class", 32'(acc_class), 2);
    check("R8", "conflict latency", 32'(acc_lat), T_RP + T_RCD + CL);
    issue(PRE, 2, 0, 1'b1, "R3");
    probe(ACT, 2, 4, 1'b1, "R3", "closed-bank pre left bank usable");
  endtask

  task automatic t_wtr;
    issue(WR, 0, 5, 1'b1, "R7");
    check("R8", "write hit class", 32'(acc_class), 0);
    idle(T_WTR - 2);
    probe(RD, 0, 5, 1'b0, "R7", "rd before twtr");
    idle(1);
    probe(RD, 0, 5, 1'b1, "R7", "rd at twtr");
    idle(CWL - T_WTR - 1);
    check("R9", "wr_due early", 32'(wr_due), 0);
    idle(1);
    check("R9", "wr_due on time", 32'(wr_due), 1);
  endtask

  task automatic t_faw;
    for (int b = 4; b < 8; b++) issue(ACT, b, 0, 1'b1, "R5");
    idle(T_FAW - 5);
    probe(ACT, 2, 4, 1'b0, "R5", "fifth act inside window");
    idle(1);
    probe(ACT, 2, 4, 1'b1, "R5", "fifth act at window end");
  endtask

  task automatic t_refresh;
    idle(T_RAS + 2);
    issue(PRE, 0, 0, 1'b1, "R6");
    issue(PRE, 1, 0, 1'b1, "R6");
    for (int b = 4; b < 8; b++) issue(PRE, b, 0, 1'b1, "R6");
    probe(REF, 0, 0, 1'b0, "R6", "ref right after pre");
    idle(T_RP - 2);
    probe(REF, 0, 0, 1'b0, "R6", "ref one cycle before trp");
    idle(1);
    probe(REF, 0, 0, 1'b1, "R6", "ref once all idle");
    issue(REF, 0, 0, 1'b1, "R6");
    probe(ACT, 0, 1, 1'b0, "R6", "act during refresh");
    probe(NOP, 0, 0, 1'b1, "R6", "nop during refresh");
    idle(T_RFC - 2);
    probe(ACT, 0, 1, 1'b0, "R6", "act one cycle before trfc");
    idle(1);
    probe(ACT, 0, 1, 1'b1, "R6", "act at trfc");
  endtask

  task automatic t_violation;
    check("R10", "violation before", 32'(violation), 0);
    issue(ACT, 3, 1, 1'b1, "R10");
    issue(PRE, 3, 0, 1'b0, "R10");
    check("R10", "violation set", 32'(violation), 1);
    check("R10", "no classification", 32'(acc_valid), 0);
    idle(T_RCD - 2);
    probe(RD, 3, 1, 1'b1, "R10", "bank still open");
    probe(ACT, 3, 2, 1'b0, "R10", "bank not closed");
    idle(5);
    check("R10", "violation sticky", 32'(violation), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    t_reset;
    t_rcd_miss_hit;
    t_ras_rp_conflict;
    t_wtr;
    t_faw;
    t_refresh;
    t_violation;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule